// File: doc/BRIEF.md
# Two-Way Branch Divergence Sequencer

This block steers a lockstep group of lanes through one two-way conditional branch. When a branch request is accepted it captures the lanes that are live at that moment and the per-lane condition bits, and splits the live lanes into a "condition true" group and a "condition false" group. It then drives the execution mask for the true group first. When the execution side signals that this pass is over, it drives the mask for the false group. Only one group ever holds the mask at a time. A group with no lanes gets no pass at all, so a branch on which every live lane agrees costs one pass instead of two.

When the last pass is over, the execution mask goes back to the mask captured at the request and a single-cycle reconvergence strobe is raised. A counter gives the number of passes the branch used: 0, 1 or 2. The sequencer handles one branch at a time and holds its ready output low until the branch has finished.

Top module: `simt_branch_seq`

## Requirements
- R1: `br_ready` is 1 only while `phase` is idle (code 0). A `br_valid` pulse while a branch is in progress is refused and changes neither `exec_mask` nor `phase`.
- R2: After a request is accepted with at least one live lane whose condition bit is 1, the next cycle shows `phase` = 1 (true pass) and `exec_mask` = `live_mask & br_cond`.
- R3: On `path_done` during the true pass, if any live lane has condition 0, the next cycle shows `phase` = 2 (false pass) and `exec_mask` = `live_mask & ~br_cond`.
- R4: When every live lane has condition 1, only the true pass is issued. The false phase is never entered and the pass count is 1.
- R5: When every live lane has condition 0, the sequencer goes straight from idle to `phase` = 2 and the pass count is 1.
- R6: Lanes whose `live_mask` bit is 0 stay at 0 in `exec_mask` during both passes, whatever their condition bit.
- R7: In the cycle after `path_done` ends the last issued pass, `phase` is 0, `exec_mask` equals the captured `live_mask`, and `reconv` is 1 for exactly one cycle.
- R8: `pass_cnt` is 2 at reconvergence for a divergent branch. A request with an all-zero `live_mask` issues no pass: in the next cycle `reconv` is 1, `pass_cnt` is 0 and `phase` stays 0.
- R9: After reset, `phase` is 0, `exec_mask` is 0, `reconv` is 0, `pass_cnt` is 0 and `br_ready` is 1.
- R10: `path_done` while idle has no effect. `exec_mask` and `phase` stay unchanged and `reconv` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch request |
| br_ready | output | 1 | Sequencer can accept a branch |
| live_mask | input | LANES | Lanes active at branch time |
| br_cond | input | LANES | Per-lane branch condition |
| path_done | input | 1 | Current pass finished |
| exec_mask | output | LANES | Lanes enabled for execution |
| phase | output | 2 | 0 idle, 1 true pass, 2 false pass |
| reconv | output | 1 | One-cycle reconvergence strobe |
| pass_cnt | output | 2 | Passes issued for the current or last branch |

## Verification
The bench builds the sequencer with the default of 32 lanes, so every mask pattern is a full 32-bit word. This setting makes it possible to try half splits, interleaved lanes, live masks with holes whose condition bits are deliberately set the opposite way, and an empty live mask. Requests that arrive while a branch is in progress and completion strobes that arrive while idle are both driven, so the refusal and the no-effect behaviour are observed at the ports.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRUE  = 2'd1,
        PH_FALSE = 2'd2
    } phase_e;

    localparam int PASS_W = 2;

    // number of masked passes a branch needs given which groups are populated
    function automatic logic [PASS_W-1:0] passes_for(input logic t_any, input logic f_any);
        return PASS_W'(t_any) + PASS_W'(f_any);
    endfunction

endpackage

// File: rtl/lane_split.sv
module lane_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] live,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] t_mask,
    output logic [LANES-1:0] f_mask,
    output logic             t_any,
    output logic             f_any
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign t_mask[g] = live[g] &  cond[g];
        assign f_mask[g] = live[g] & ~cond[g];
    end

    assign t_any = |t_mask;
    assign f_any = |f_mask;
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import simt_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [LANES-1:0]  live,
    input  logic [LANES-1:0]  t_mask,
    input  logic [LANES-1:0]  f_mask,
    input  logic              t_any,
    input  logic              f_any,
    input  logic              path_done,
    output phase_e            phase,
    output logic [LANES-1:0]  exec_mask,
    output logic              reconv,
    output logic [PASS_W-1:0] passes
);
    logic [LANES-1:0] base_q;
    logic [LANES-1:0] fsave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            exec_mask <= '0;
            base_q    <= '0;
            fsave_q   <= '0;
            reconv    <= 1'b0;
            passes    <= '0;
        end else begin
            reconv <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        base_q  <= live;
                        fsave_q <= f_mask;
                        passes  <= passes_for(t_any, f_any) == 0 ? '0 : PASS_W'(1);
                        if (t_any) begin
                            phase     <= PH_TRUE;
                            exec_mask <= t_mask;
                        end else if (f_any) begin
                            phase     <= PH_FALSE;
                            exec_mask <= f_mask;
                        end else begin
                            exec_mask <= live;
                            reconv    <= 1'b1;
                        end
                    end
                end
                PH_TRUE: begin
                    if (path_done) begin
                        if (|fsave_q) begin
                            phase     <= PH_FALSE;
                            exec_mask <= fsave_q;
                            passes    <= passes + PASS_W'(1);
                        end else begin
                            phase     <= PH_IDLE;
                            exec_mask <= base_q;
                            reconv    <= 1'b1;
                        end
                    end
                end
                PH_FALSE: begin
                    if (path_done) begin
                        phase     <= PH_IDLE;
                        exec_mask <= base_q;
                        reconv    <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R6
    mask_in_base_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> ((exec_mask & ~base_q) == '0));

    // R3
    paths_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FALSE && $past(phase) == PH_TRUE) |-> ((exec_mask & $past(exec_mask)) == '0));

    // R8
    no_empty_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (exec_mask != '0));

    // R7
    false_done_reconv_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FALSE && path_done) |=> (reconv && phase == PH_IDLE && exec_mask == base_q));

    // R8
    pass_bound_chk: assert property (@(posedge clk) disable iff (rst)
        passes <= PASS_W'(2));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !accept && path_done) |=> ($stable(exec_mask) && !reconv));
endmodule

// File: rtl/simt_branch_seq.sv
module simt_branch_seq
    import simt_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    output logic             br_ready,
    input  logic [LANES-1:0] live_mask,
    input  logic [LANES-1:0] br_cond,
    input  logic             path_done,
    output logic [LANES-1:0] exec_mask,
    output logic [1:0]       phase,
    output logic             reconv,
    output logic [1:0]       pass_cnt
);
    logic [LANES-1:0]  t_mask, f_mask;
    logic              t_any, f_any;
    logic              accept;
    phase_e            ph;
    logic [PASS_W-1:0] passes;

    lane_split #(.LANES(LANES)) u_split (
        .live   (live_mask),
        .cond   (br_cond),
        .t_mask (t_mask),
        .f_mask (f_mask),
        .t_any  (t_any),
        .f_any  (f_any)
    );

    div_fsm #(.LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .live      (live_mask),
        .t_mask    (t_mask),
        .f_mask    (f_mask),
        .t_any     (t_any),
        .f_any     (f_any),
        .path_done (path_done),
        .phase     (ph),
        .exec_mask (exec_mask),
        .reconv    (reconv),
        .passes    (passes)
    );

    assign br_ready = (ph == PH_IDLE);
    assign accept   = br_valid & br_ready;
    assign phase    = ph;
    assign pass_cnt = passes;

    // R1
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && br_valid && !path_done) |=> $stable(exec_mask));
endmodule

// File: tb/tb_simt_branch_seq.sv
module tb_simt_branch_seq;
    localparam int LANES = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             br_valid;
    logic             br_ready;
    logic [LANES-1:0] live_mask;
    logic [LANES-1:0] br_cond;
    logic             path_done;
    logic [LANES-1:0] exec_mask;
    logic [1:0]       phase;
    logic             reconv;
    logic [1:0]       pass_cnt;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    simt_branch_seq #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_ready(br_ready),
        .live_mask(live_mask), .br_cond(br_cond), .path_done(path_done),
        .exec_mask(exec_mask), .phase(phase), .reconv(reconv), .pass_cnt(pass_cnt)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic request(input logic [LANES-1:0] lv, input logic [LANES-1:0] cd);
        @(negedge clk);
        br_valid  = 1'b1;
        live_mask = lv;
        br_cond   = cd;
        @(negedge clk);
        br_valid  = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        path_done = 1'b1;
        @(negedge clk);
        path_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "phase", 64'(phase), 64'd0);
        chk("R9", "exec", 64'(exec_mask), 64'd0);
        chk("R9", "reconv", 64'(reconv), 64'd0);
        chk("R9", "passes", 64'(pass_cnt), 64'd0);
        chk("R9", "ready", 64'(br_ready), 64'd1);
    endtask

    task automatic t_diverge();
        request(32'hFFFF_FFFF, 32'h0000_FFFF);
        chk("R2", "phase", 64'(phase), 64'd1);
        chk("R2", "exec", 64'(exec_mask), 64'h0000_FFFF);
        chk("R1", "ready busy", 64'(br_ready), 64'd0);
        request(32'h0000_0001, 32'h0000_0001);
        chk("R1", "exec after refused", 64'(exec_mask), 64'h0000_FFFF);
        chk("R1", "phase after refused", 64'(phase), 64'd1);
        done_pulse();
        chk("R3", "phase", 64'(phase), 64'd2);
        chk("R3", "exec", 64'(exec_mask), 64'hFFFF_0000);
        done_pulse();
        chk("R7", "phase", 64'(phase), 64'd0);
        chk("R7", "exec restored", 64'(exec_mask), 64'hFFFF_FFFF);
        chk("R7", "reconv", 64'(reconv), 64'd1);
        chk("R8", "passes", 64'(pass_cnt), 64'd2);
        @(negedge clk);
        chk("R7", "reconv one cycle", 64'(reconv), 64'd0);
    endtask

    task automatic t_uniform_true();
        request(32'h0F0F_0F0F, 32'hFFFF_FFFF);
        chk("R4", "phase", 64'(phase), 64'd1);
        chk("R4", "exec", 64'(exec_mask), 64'h0F0F_0F0F);
        done_pulse();
        chk("R4", "phase after", 64'(phase), 64'd0);
        chk("R4", "reconv", 64'(reconv), 64'd1);
        chk("R4", "passes", 64'(pass_cnt), 64'd1);
        chk("R7", "exec restored", 64'(exec_mask), 64'h0F0F_0F0F);
    endtask

    task automatic t_uniform_false();
        request(32'h0000_00FF, 32'hFFFF_FF00);
        chk("R5", "phase", 64'(phase), 64'd2);
        chk("R6", "exec ignores dead cond", 64'(exec_mask), 64'h0000_00FF);
        done_pulse();
        chk("R5", "reconv", 64'(reconv), 64'd1);
        chk("R5", "passes", 64'(pass_cnt), 64'd1);
    endtask

    task automatic t_holes();
        request(32'hF0F0_F0F0, 32'hAAAA_AAAA);
        chk("R6", "true mask", 64'(exec_mask), 64'hA0A0_A0A0);
        done_pulse();
        chk("R6", "false mask", 64'(exec_mask), 64'h5050_5050);
        done_pulse();
        chk("R7", "exec restored", 64'(exec_mask), 64'hF0F0_F0F0);
    endtask

    task automatic t_empty();
        request(32'h0000_0000, 32'hFFFF_FFFF);
        chk("R8", "phase empty", 64'(phase), 64'd0);
        chk("R8", "reconv empty", 64'(reconv), 64'd1);
        chk("R8", "passes empty", 64'(pass_cnt), 64'd0);
        chk("R8", "exec empty", 64'(exec_mask), 64'd0);
    endtask

    task automatic t_idle_done();
        request(32'h1234_5678, 32'hFFFF_FFFF);
        done_pulse();
        @(negedge clk);
        done_pulse();
        chk("R10", "exec", 64'(exec_mask), 64'h1234_5678);
        chk("R10", "phase", 64'(phase), 64'd0);
        chk("R10", "reconv", 64'(reconv), 64'd0);
    endtask

    initial begin
        rst = 1'b1; br_valid = 1'b0; path_done = 1'b0;
        live_mask = '0; br_cond = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_diverge();
        t_uniform_true();
        t_uniform_false();
        t_holes();
        t_empty();
        t_idle_done();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule